// File: doc/BRIEF.md
# ADC Completion Event Router

This block sits between the sequencer of an analog-to-digital converter and the rest of the chip. For every finished conversion it stores the result in a result register for that channel. When a conversion run ends, it sets a completion flag. Depending on a routing bit, the end of the run becomes either a level interrupt to the processor or a level request to a DMA engine. The two destinations are never used together.

Software sets up the block through a small register port: a control word (interrupt enable, routing, conversion mode), a status word holding the completion flag, and one readable result register per channel. In DMA routing the engine reads the results through a separate read port. Each acknowledged read clears the flag. The request stays up until the engine has fetched as many results as the run produced.

Top module: `adc_done_router`

## Requirements
- R1: The completion flag (status register, address 1, bit 0) is set when a run ends. In single mode (control bits [3:2] = 0) every conversion strobe ends a run. In scan mode (1) or multi mode (2) a run ends only on a strobe with `conv_last` high.
- R2: With CPU routing (control bit 1 = 0), `cpu_irq` is high exactly while the enable (control bit 0) and the completion flag are both 1.
- R3: With DMA routing (control bit 1 = 1), the end of a run raises `dma_req` and `cpu_irq` stays low even when the enable bit is 1.
- R4: An acknowledged DMA read (`dma_ack` while `dma_req` is high) clears the completion flag.
- R5: In single mode, one acknowledged DMA read ends the request, so exactly one transfer is asked for per conversion end.
- R6: In scan or multi mode, `dma_req` stays high until the acknowledge whose count equals the number of conversions in the run, and drops in the cycle after that acknowledge.
- R7: Each result register is 16 bits, holding the 10-bit result in bits [15:6] with bits [5:0] reading 0. It is read at register address 2 plus the channel index, or on `dma_rdata` for `dma_rd_chan`. A conversion of another channel does not change it.
- R8: Software clears the flag only by writing 0 to status bit 0 after a status read that returned the flag as 1. Writing 1, or writing 0 without that read, leaves the flag unchanged.
- R9: When a run ends in the same cycle as a clear (by software or by a DMA acknowledge), the flag stays 1.
- R10: After reset the control word, the flag and all result registers read 0, with CPU routing, and both `cpu_irq` and `dma_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| conv_chan | input | 3 | Channel of the finished conversion |
| conv_last | input | 1 | Strobe marks the last channel of a scan or multi run |
| conv_result | input | 10 | Raw conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address (0 control, 1 status, 2+ch result) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| dma_ack | input | 1 | DMA engine has taken one result |
| dma_rd_chan | input | 3 | Channel the DMA engine is reading |
| dma_rdata | output | 16 | Result word for `dma_rd_chan` |
| cpu_irq | output | 1 | Level interrupt to the processor |
| dma_req | output | 1 | Level transfer request to the DMA engine |

## Verification
The flag can see a set and a clear in the same cycle. In CPU routing this happens when the bench drives a status write of 0, after a valid status read, in the same cycle as a run-ending strobe. In DMA routing it happens when the bench drives an acknowledge together with a new single-mode conversion. In both cases the bench expects the flag to read 1 afterwards. In the DMA case it also expects the request to stay high for a fresh transfer, and the scoreboard expects the acknowledged read to return the old result of the read channel.

// File: rtl/adc_rt_pkg.sv
package adc_rt_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_SCAN   = 2'd1,
        MODE_MULTI  = 2'd2
    } conv_mode_e;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_STAT     = 1;
    localparam int ADDR_RES_BASE = 2;

    typedef struct packed {
        logic       irq_en;
        logic       dma_sel;
        logic [1:0] mode;
        logic       flag;
        logic       seen;
    } flag_state_t;

endpackage

// File: rtl/adc_rt_results.sv
module adc_rt_results #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int REG_W  = 16,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int PAD_W = REG_W - RES_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          conv_done,
    input  logic [CH_W-1:0]               conv_chan,
    input  logic [RES_W-1:0]              conv_result,
    output logic [NUM_CH-1:0][REG_W-1:0]  res_q
);

    logic [NUM_CH-1:0][REG_W-1:0] res_d;

    always_comb begin
        res_d = res_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (conv_done && (conv_chan == CH_W'(i))) begin
                res_d[i] = {conv_result, {PAD_W{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
        AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(conv_done && conv_chan == CH_W'(g)) |=> $stable(res_q[g])); // R7
    end

endmodule

// File: rtl/adc_rt_flag.sv
module adc_rt_flag
    import adc_rt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_evt,
    input  logic       dma_clr,
    input  logic       ctrl_wr,
    input  logic       stat_wr,
    input  logic       stat_rd,
    input  logic [3:0] wbits,
    output logic       irq_en,
    output logic       dma_sel,
    output logic [1:0] mode,
    output logic       flag,
    output logic       cpu_irq
);

    flag_state_t st_d, st_q;
    logic        sw_clr;

    always_comb begin
        st_d   = st_q;
        sw_clr = stat_wr && !wbits[0] && st_q.seen;
        if (ctrl_wr) begin
            st_d.irq_en  = wbits[0];
            st_d.dma_sel = wbits[1];
            st_d.mode    = wbits[3:2];
        end
        if (stat_rd && st_q.flag) begin
            st_d.seen = 1'b1;
        end
        if (done_evt) begin
            st_d.flag = 1'b1;
            st_d.seen = 1'b0;
        end else if (sw_clr || dma_clr) begin
            st_d.flag = 1'b0;
            st_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_en  = st_q.irq_en;
    assign dma_sel = st_q.dma_sel;
    assign mode    = st_q.mode;
    assign flag    = st_q.flag;
    assign cpu_irq = st_q.irq_en && st_q.flag && !st_q.dma_sel;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> flag); // R1
    AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clr && !done_evt) |=> !flag); // R4
    AST_W1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wbits[0] && !done_evt && !dma_clr) |=> $stable(flag)); // R8

endmodule

// File: rtl/adc_rt_dma_seq.sv
module adc_rt_dma_seq
    import adc_rt_pkg::*;
#(
    parameter int NUM_CH  = 8,
    localparam int CNT_W  = $clog2(NUM_CH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_done,
    input  logic       conv_last,
    input  logic [1:0] mode,
    input  logic       dma_sel,
    input  logic       dma_ack,
    output logic       done_evt,
    output logic       dma_clr,
    output logic       dma_req
);

    typedef struct packed {
        logic [CNT_W-1:0] seq_cnt;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] ack_cnt;
        logic             req;
    } seq_state_t;

    seq_state_t sq_d, sq_q;
    logic       single;

    always_comb begin
        sq_d     = sq_q;
        single   = (mode == MODE_SINGLE);
        done_evt = conv_done && (single || conv_last);
        dma_clr  = dma_ack && sq_q.req;

        if (done_evt) begin
            sq_d.seq_cnt = '0;
            if (dma_sel) begin
                sq_d.req     = 1'b1;
                sq_d.ack_cnt = '0;
                sq_d.len     = single ? CNT_W'(1) : sq_q.seq_cnt + CNT_W'(1);
            end
        end else if (conv_done && sq_q.seq_cnt < CNT_W'(NUM_CH - 1)) begin
            sq_d.seq_cnt = sq_q.seq_cnt + CNT_W'(1);
        end

        if (dma_clr && !(done_evt && dma_sel)) begin
            if (sq_q.ack_cnt + CNT_W'(1) >= sq_q.len) begin
                sq_d.req     = 1'b0;
                sq_d.ack_cnt = '0;
            end else begin
                sq_d.ack_cnt = sq_q.ack_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign dma_req = sq_q.req;

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clr && !done_evt && sq_q.ack_cnt + CNT_W'(1) == sq_q.len) |=> !dma_req); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req); // R6
    AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && dma_sel && mode == MODE_SINGLE) |=> (sq_q.len == CNT_W'(1))); // R5

endmodule

// File: rtl/adc_done_router.sv
module adc_done_router
    import adc_rt_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int RES_W   = 10,
    parameter int REG_W   = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = $clog2(NUM_CH + ADDR_RES_BASE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_chan,
    input  logic              conv_last,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dma_ack,
    input  logic [CH_W-1:0]   dma_rd_chan,
    output logic [REG_W-1:0]  dma_rdata,
    output logic              cpu_irq,
    output logic              dma_req
);

    logic [NUM_CH-1:0][REG_W-1:0] res_q;
    logic              done_evt, dma_clr;
    logic              irq_en, dma_sel, flag;
    logic [1:0]        mode;
    logic              ctrl_wr, stat_wr, stat_rd;
    logic [ADDR_W-1:0] res_idx;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign stat_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));
    assign stat_rd = reg_rd && (reg_addr == ADDR_W'(ADDR_STAT));
    assign res_idx = reg_addr - ADDR_W'(ADDR_RES_BASE);

    adc_rt_results #(.NUM_CH(NUM_CH), .RES_W(RES_W), .REG_W(REG_W)) u_results (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_chan   (conv_chan),
        .conv_result (conv_result),
        .res_q       (res_q)
    );

    adc_rt_dma_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_last (conv_last),
        .mode      (mode),
        .dma_sel   (dma_sel),
        .dma_ack   (dma_ack),
        .done_evt  (done_evt),
        .dma_clr   (dma_clr),
        .dma_req   (dma_req)
    );

    adc_rt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_evt(done_evt),
        .dma_clr (dma_clr),
        .ctrl_wr (ctrl_wr),
        .stat_wr (stat_wr),
        .stat_rd (stat_rd),
        .wbits   (reg_wdata[3:0]),
        .irq_en  (irq_en),
        .dma_sel (dma_sel),
        .mode    (mode),
        .flag    (flag),
        .cpu_irq (cpu_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[3:0] = {mode, dma_sel, irq_en};
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata[0] = flag;
        end else if (reg_addr >= ADDR_W'(ADDR_RES_BASE) && res_idx < ADDR_W'(NUM_CH)) begin
            reg_rdata = res_q[res_idx[CH_W-1:0]];
        end
    end

    assign dma_rdata = res_q[dma_rd_chan];

    AST_ROUTE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && dma_sel && !ctrl_wr) |=> (dma_req && !cpu_irq)); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (reg_addr != ADDR_W'(ADDR_STAT) || reg_rdata[0])); // R2

endmodule

// File: tb/adc_done_router_bench.sv
module adc_done_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic        conv_last = 1'b0;
    logic [9:0]  conv_result = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dma_ack = 1'b0;
    logic [2:0]  dma_rd_chan = '0;
    logic [15:0] dma_rdata;
    logic        cpu_irq, dma_req;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_res [8];
    logic [15:0] exp_data [$];
    string       exp_tag  [$];
    logic [15:0] rv;

    always #5 clk = ~clk;

    adc_done_router u_adc_done_router (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_chan(conv_chan),
        .conv_last(conv_last), .conv_result(conv_result), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dma_ack(dma_ack), .dma_rd_chan(dma_rd_chan),
        .dma_rdata(dma_rdata), .cpu_irq(cpu_irq), .dma_req(dma_req)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every acknowledged DMA read is compared to the queued expectation
    always @(negedge clk) begin
        if (dma_ack && dma_req) begin
            if (exp_data.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected DMA read actual=%h expected=none", dma_rdata);
            end else begin
                chk(exp_tag.pop_front(), dma_rdata, exp_data.pop_front());
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        step(); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); v = reg_rdata;
        step(); reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        step(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(); reg_wr = 1'b0;
    endtask

    task automatic conv(input logic [2:0] ch, input logic [9:0] r, input logic last);
        step(); conv_done = 1'b1; conv_chan = ch; conv_result = r; conv_last = last;
        step(); conv_done = 1'b0; conv_last = 1'b0;
        model_res[ch] = {r, 6'b0};
    endtask

    task automatic ack(input logic [2:0] ch, input string tag);
        step(); dma_ack = 1'b1; dma_rd_chan = ch;
        exp_data.push_back(model_res[ch]); exp_tag.push_back(tag);
        step(); dma_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model_res[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk("R10 irq", {15'b0, cpu_irq}, 16'h0);
        chk("R10 req", {15'b0, dma_req}, 16'h0);
        rd(4'd0, rv); chk("R10 ctrl", rv, 16'h0);
        rd(4'd1, rv); chk("R10 flag", rv, 16'h0);
        rd(4'd5, rv); chk("R10 result", rv, 16'h0);

        // CPU routing, irq enabled, single mode
        wr(4'd0, 16'h0001);
        conv(3'd2, 10'h3FF, 1'b0);
        chk("R1 single flag irq", {15'b0, cpu_irq}, 16'h1);
        chk("R2 irq on", {15'b0, cpu_irq}, 16'h1);
        rd(4'd4, rv); chk("R7 left-justified", rv, 16'hFFC0);

        // R8: write 0 without a prior read is ignored
        wr(4'd1, 16'h0000);
        rd(4'd1, rv); chk("R8 no-read clear ignored", rv, 16'h0001);
        // flag was just read as 1: write 1 is ignored
        wr(4'd1, 16'h0001);
        rd(4'd1, rv); chk("R8 write1 ignored", rv, 16'h0001);
        wr(4'd1, 16'h0000);
        rd(4'd1, rv); chk("R8 read-then-clear", rv, 16'h0000);
        chk("R2 irq off", {15'b0, cpu_irq}, 16'h0);

        // R2: enable off keeps irq low although the flag is set
        wr(4'd0, 16'h0000);
        conv(3'd3, 10'h155, 1'b0);
        rd(4'd1, rv); chk("R2 flag set", rv, 16'h0001);
        chk("R2 disabled irq", {15'b0, cpu_irq}, 16'h0);
        wr(4'd1, 16'h0000);

        // scan mode: only the last strobe ends the run
        wr(4'd0, 16'h0005);
        conv(3'd0, 10'h001, 1'b0);
        conv(3'd1, 10'h002, 1'b0);
        rd(4'd1, rv); chk("R1 scan mid-run", rv, 16'h0000);
        conv(3'd2, 10'h003, 1'b1);
        rd(4'd1, rv); chk("R1 scan end", rv, 16'h0001);

        // R9: software clear and run end in the same cycle
        step(); reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 16'h0;
        conv_done = 1'b1; conv_chan = 3'd4; conv_result = 10'h0AA; conv_last = 1'b1;
        step(); reg_wr = 1'b0; conv_done = 1'b0; conv_last = 1'b0;
        model_res[4] = {10'h0AA, 6'b0};
        rd(4'd1, rv); chk("R9 set wins sw", rv, 16'h0001);
        wr(4'd1, 16'h0000);
        rd(4'd1, rv); chk("R8 cleared", rv, 16'h0000);

        // DMA routing, single mode, irq enable on
        wr(4'd0, 16'h0003);
        conv(3'd5, 10'h155, 1'b0);
        chk("R3 req up", {15'b0, dma_req}, 16'h1);
        chk("R3 irq held low", {15'b0, cpu_irq}, 16'h0);
        ack(3'd5, "R7 dma single");
        chk("R5 req drops", {15'b0, dma_req}, 16'h0);
        rd(4'd1, rv); chk("R4 flag cleared", rv, 16'h0000);

        // DMA routing, multi mode, four conversions
        wr(4'd0, 16'h000B);
        conv(3'd0, 10'h011, 1'b0);
        conv(3'd1, 10'h022, 1'b0);
        conv(3'd2, 10'h033, 1'b0);
        conv(3'd3, 10'h044, 1'b1);
        chk("R6 req up", {15'b0, dma_req}, 16'h1);
        for (int i = 0; i < 3; i++) begin
            ack(3'(i), "R6 burst data");
            chk("R6 req held", {15'b0, dma_req}, 16'h1);
        end
        ack(3'd3, "R6 burst data");
        chk("R6 req drops after final", {15'b0, dma_req}, 16'h0);
        rd(4'd3, rv); chk("R7 ch1 kept", rv, {10'h022, 6'b0});

        // R9: DMA acknowledge and new run end in the same cycle (single mode)
        wr(4'd0, 16'h0003);
        conv(3'd6, 10'h0F0, 1'b0);
        step(); dma_ack = 1'b1; dma_rd_chan = 3'd6;
        exp_data.push_back(model_res[6]); exp_tag.push_back("R9 dma old data");
        conv_done = 1'b1; conv_chan = 3'd7; conv_result = 10'h10F;
        step(); dma_ack = 1'b0; conv_done = 1'b0;
        model_res[7] = {10'h10F, 6'b0};
        rd(4'd1, rv); chk("R9 set wins dma", rv, 16'h0001);
        chk("R9 req reloaded", {15'b0, dma_req}, 16'h1);
        ack(3'd7, "R7 dma ch7");
        chk("R5 req drops again", {15'b0, dma_req}, 16'h0);
        rd(4'd9, rv); chk("R7 ch7 reg", rv, {10'h10F, 6'b0});
        rd(4'd6, rv); chk("R7 ch4 untouched", rv, {10'h0AA, 6'b0});

        repeat (2) step();
        if (exp_data.size() != 0) begin
            errors++;
            $display("FAIL R6 missing reads actual=%0d expected=0", exp_data.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule